// File: doc/BRIEF.md
# Sleep State Output and Reset Controller

This block converts a requested platform power state (S0, S3, S4 or S5) into the active-low S3, S4 and S5 power-plane controls, a LAN and a WLAN sleep control, and an active-low platform reset. Entry into a deeper state takes effect on the next clock edge. Exit is sequenced one level per cycle: S5 is released first, then S4, then S3, and the platform reset follows one cycle later.

Exit can be stalled in two ways. A battery-low condition freezes the block while it sits in S4 or S5. An exit-holdoff input freezes it once the subsystem sleep indication has dropped. The subsystem sleep indication passes through a stretcher with a programmable minimum assertion width. The stretched copy gates the LAN sleep output and decides when the holdoff input takes effect. A power-good input forces the platform reset low at once, in any state.

Top module: `slp_rst_ctrl`

## Requirements
- R1: `tgt_state_i` is encoded as 2'b00=S0, 2'b01=S3, 2'b10=S4 and 2'b11=S5. A request deeper than the current level is applied on the next clock edge. `slp_s3_no` is low in S3, S4 and S5. `slp_s4_no` is low in S4 and S5. `slp_s5_no` is low only in S5.
- R2: `plt_rst_no` goes low on the same edge that the block enters any sleep level. On exit it rises one cycle after `slp_s3_no` is released, provided `pwr_good_i` is high.
- R3: While `pwr_good_i` is low, `plt_rst_no` is low in every state, with no clock edge needed.
- R4: When the requested state is shallower than the current level, the level moves up one step per cycle: S5 to S4, S4 to S3, then S3 to S0.
- R5: While `batt_low_i` is high and the level is S4 or S5, the level does not move toward S0.
- R6: While `exit_hold_ni` is low and the stretched subsystem sleep is deasserted, the level does not move toward S0. While the stretched subsystem sleep is asserted, `exit_hold_ni` has no effect.
- R7: `slp_lan_no` is low only when the level is not S0 and the stretched subsystem sleep is asserted. In S0 it is high.
- R8: `slp_wlan_no` is low exactly when the level is not S0.
- R9: The stretched subsystem sleep asserts one cycle after `sub_sleep_i` rises. It then stays asserted for at least `min_width_i` cycles, and for as long as `sub_sleep_i` stays high. A `min_width_i` of 0 or 1 gives plain one-cycle-delayed tracking.
- R10: While `rst_ni` is low, the level is S0, every sleep control is high and `plt_rst_no` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tgt_state_i | input | 2 | Requested power state (00 S0, 01 S3, 10 S4, 11 S5) |
| pwr_good_i | input | 1 | Core rails good; low forces platform reset |
| batt_low_i | input | 1 | Battery low; blocks exit from S4/S5 |
| exit_hold_ni | input | 1 | Active-low exit holdoff |
| sub_sleep_i | input | 1 | Subsystem sleep indication, high = asleep |
| min_width_i | input | MW_W | Minimum width of stretched subsystem sleep, in cycles |
| slp_s3_no | output | 1 | Active-low S3 power-plane control |
| slp_s4_no | output | 1 | Active-low S4 power-plane control |
| slp_s5_no | output | 1 | Active-low S5 power-plane control |
| slp_lan_no | output | 1 | Active-low LAN sleep control |
| slp_wlan_no | output | 1 | Active-low WLAN sleep control |
| plt_rst_no | output | 1 | Active-low platform reset |

## Verification
The level register drives all three plane controls and the WLAN control. A wrong level therefore shows on those pins in the cycle after the bad edge, as a code outside the S3 ⊂ S4 ⊂ S5 nesting or as a step that skips a level during exit. A stretcher counter that is off by one moves the LAN release by exactly one cycle, so the bench samples on both sides of the expected release edge. A reset-release flag that is wrong shows as `plt_rst_no` rising in the same cycle as `slp_s3_no`, or staying low one cycle too long.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [1:0] {
    LVL_S0 = 2'd0,
    LVL_S3 = 2'd1,
    LVL_S4 = 2'd2,
    LVL_S5 = 2'd3
  } slp_lvl_e;
endpackage

// File: rtl/slp_width_stretch.sv
module slp_width_stretch #(
  parameter int MW_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sub_sleep_i,
  input  logic [MW_W-1:0] min_width_i,
  output logic            sub_eff_o
);
  logic            eff_q;
  logic [MW_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eff_q <= 1'b0;
      cnt_q <= '0;
    end else if (!eff_q) begin
      if (sub_sleep_i) begin
        eff_q <= 1'b1;
        cnt_q <= min_width_i;
      end
    end else begin
      if (cnt_q > MW_W'(1)) cnt_q <= cnt_q - MW_W'(1);
      if (!sub_sleep_i && cnt_q <= MW_W'(1)) eff_q <= 1'b0;
    end
  end

  assign sub_eff_o = eff_q;

  AST_DROP_AFTER_INPUT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(eff_q) |-> !$past(sub_sleep_i)); // R9
  AST_RISE_FOLLOWS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eff_q) |-> $past(sub_sleep_i)); // R9
endmodule

// File: rtl/slp_level_seq.sv
module slp_level_seq
  import slp_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  slp_lvl_e tgt_i,
  input  logic     batt_low_i,
  input  logic     exit_hold_ni,
  input  logic     sub_eff_i,
  output slp_lvl_e lvl_o,
  output logic     rel_o
);
  slp_lvl_e lvl_q, lvl_d;
  logic     rel_q;
  logic     batt_block, hold_block;

  assign batt_block = batt_low_i && (lvl_q == LVL_S4 || lvl_q == LVL_S5);
  assign hold_block = !exit_hold_ni && !sub_eff_i;

  always_comb begin
    lvl_d = lvl_q;
    if (tgt_i > lvl_q) lvl_d = tgt_i;  // entry is immediate
    else if (tgt_i < lvl_q && !batt_block && !hold_block)
      lvl_d = slp_lvl_e'(lvl_q - 2'd1); // exit one step at a time
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= LVL_S0;
      rel_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      rel_q <= (lvl_q == LVL_S0) && (lvl_d == LVL_S0);
    end
  end

  assign lvl_o = lvl_q;
  assign rel_o = rel_q;

  AST_EXIT_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q < $past(lvl_q)) |-> (lvl_q == slp_lvl_e'($past(lvl_q) - 2'd1))); // R4
  AST_BATT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (batt_low_i && lvl_q >= LVL_S4) |=> (lvl_q >= $past(lvl_q))); // R5
  AST_HOLDOFF_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exit_hold_ni && !sub_eff_i) |=> (lvl_q >= $past(lvl_q))); // R6
  AST_REL_ONLY_IN_S0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_q |-> (lvl_q == LVL_S0)); // R2
endmodule

// File: rtl/slp_rst_ctrl.sv
module slp_rst_ctrl
  import slp_pkg::*;
#(
  parameter int MW_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      tgt_state_i,
  input  logic            pwr_good_i,
  input  logic            batt_low_i,
  input  logic            exit_hold_ni,
  input  logic            sub_sleep_i,
  input  logic [MW_W-1:0] min_width_i,
  output logic            slp_s3_no,
  output logic            slp_s4_no,
  output logic            slp_s5_no,
  output logic            slp_lan_no,
  output logic            slp_wlan_no,
  output logic            plt_rst_no
);
  slp_lvl_e lvl;
  logic     sub_eff, rel;

  slp_width_stretch #(.MW_W(MW_W)) i_stretch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sub_sleep_i (sub_sleep_i),
    .min_width_i (min_width_i),
    .sub_eff_o   (sub_eff)
  );

  slp_level_seq i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tgt_i        (slp_lvl_e'(tgt_state_i)),
    .batt_low_i   (batt_low_i),
    .exit_hold_ni (exit_hold_ni),
    .sub_eff_i    (sub_eff),
    .lvl_o        (lvl),
    .rel_o        (rel)
  );

  assign slp_s3_no   = (lvl == LVL_S0);
  assign slp_s4_no   = (lvl <= LVL_S3);
  assign slp_s5_no   = (lvl != LVL_S5);
  assign slp_wlan_no = (lvl == LVL_S0);
  assign slp_lan_no  = (lvl == LVL_S0) || !sub_eff;
  assign plt_rst_no  = rel && pwr_good_i;  // power-good acts without a clock

  AST_RST_LOW_IN_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slp_s3_no |-> !plt_rst_no); // R2
  AST_RST_AFTER_S3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rel) |-> $past(slp_s3_no)); // R2
  AST_PLANES_NESTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slp_s5_no |-> !slp_s4_no) and (!slp_s4_no |-> !slp_s3_no)); // R1
endmodule

// File: tb/test_slp_rst_ctrl.sv
module test_slp_rst_ctrl;
  localparam int MW_W = 8;
  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      tgt = 2'b00;
  logic            pg = 1'b1, batt = 1'b0, hold_n = 1'b1, sub = 1'b0;
  logic [MW_W-1:0] mw = '0;
  logic            s3_n, s4_n, s5_n, lan_n, wlan_n, prst_n;
  int              checks = 0, fails = 0;
  bit              done = 0;

  always #4 clk = ~clk;

  slp_rst_ctrl #(.MW_W(MW_W)) i_slp_rst_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tgt_state_i(tgt), .pwr_good_i(pg),
    .batt_low_i(batt), .exit_hold_ni(hold_n), .sub_sleep_i(sub),
    .min_width_i(mw), .slp_s3_no(s3_n), .slp_s4_no(s4_n), .slp_s5_no(s5_n),
    .slp_lan_no(lan_n), .slp_wlan_no(wlan_n), .plt_rst_no(prst_n));

  // packed as {s5,s4,s3,wlan,lan,prst}
  localparam logic [5:0] O_S0   = 6'b111111;
  localparam logic [5:0] O_S0R  = 6'b111110;
  localparam logic [5:0] O_S3   = 6'b110010;
  localparam logic [5:0] O_S3L  = 6'b110000;
  localparam logic [5:0] O_S4   = 6'b100010;
  localparam logic [5:0] O_S5   = 6'b000010;

  function automatic logic [5:0] outs();
    return {s5_n, s4_n, s3_n, wlan_n, lan_n, prst_n};
  endfunction

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    cyc(2);
    chk("R10 outputs in reset", outs(), O_S0R);
    rst_n = 1'b1;
    cyc(1);
    chk("R10 after reset release", outs(), O_S0);
  endtask

  task automatic t_entry();
    tgt = 2'b01; cyc(1);
    chk("R1 R2 R8 enter S3", outs(), O_S3);
    tgt = 2'b10; cyc(1);
    chk("R1 enter S4", outs(), O_S4);
    tgt = 2'b11; cyc(1);
    chk("R1 enter S5", outs(), O_S5);
  endtask

  task automatic t_exit();
    tgt = 2'b00; cyc(1);
    chk("R4 step S5 released", outs(), O_S4);
    cyc(1);
    chk("R4 step S4 released", outs(), O_S3);
    cyc(1);
    chk("R2 S3 released reset held", outs(), O_S0R);
    cyc(1);
    chk("R2 reset released", outs(), O_S0);
  endtask

  task automatic t_pg();
    pg = 1'b0; #1;
    chk("R3 pg low in S0", outs(), O_S0R);
    cyc(2);
    chk("R3 pg low held", outs(), O_S0R);
    pg = 1'b1; #1;
    chk("R3 pg restored", outs(), O_S0);
  endtask

  task automatic t_direct_s5();
    tgt = 2'b11; cyc(1);
    chk("R1 direct S0 to S5", outs(), O_S5);
  endtask

  task automatic t_batt();
    batt = 1'b1; tgt = 2'b00; cyc(3);
    chk("R5 batt low blocks S5 exit", outs(), O_S5);
    batt = 1'b0; cyc(4);
    chk("R5 exit after batt clears", outs(), O_S0);
    tgt = 2'b01; cyc(1);
    batt = 1'b1; tgt = 2'b00; cyc(1);
    chk("R5 batt low no block in S3", outs(), O_S0R);
    batt = 1'b0; cyc(1);
    chk("R5 reset released from S3", outs(), O_S0);
  endtask

  task automatic t_hold();
    tgt = 2'b01; cyc(1);
    hold_n = 1'b0; tgt = 2'b00; cyc(3);
    chk("R6 holdoff blocks exit", outs(), O_S3);
    hold_n = 1'b1; cyc(1);
    chk("R6 exit after holdoff", outs(), O_S0R);
    cyc(1);
    tgt = 2'b01; cyc(1);
    hold_n = 1'b0; sub = 1'b1; tgt = 2'b00; cyc(1);
    chk("R6 R7 stretched sub asserting", outs(), O_S3L);
    cyc(1);
    chk("R6 holdoff ignored while sub asleep", outs(), O_S0R);
    sub = 1'b0; hold_n = 1'b1; cyc(2);
    chk("R6 back in S0", outs(), O_S0);
  endtask

  task automatic t_lan();
    sub = 1'b1; cyc(2);
    chk("R7 LAN high in S0 with sub asleep", outs(), O_S0);
    tgt = 2'b01; cyc(1);
    chk("R7 LAN low in S3 with sub asleep", outs(), O_S3L);
    sub = 1'b0; cyc(1);
    chk("R7 R9 LAN follows sub with width 0", outs(), O_S3);
  endtask

  task automatic t_width();
    mw = 8'd5;
    sub = 1'b1; cyc(1);
    sub = 1'b0;
    chk("R9 stretched sub asserted", outs(), O_S3L);
    cyc(4);
    chk("R9 still asserted at width-1", outs(), O_S3L);
    cyc(1);
    chk("R9 released after width", outs(), O_S3);
    mw = '0;
    tgt = 2'b00; cyc(2);
    chk("R2 final exit", outs(), O_S0);
  endtask

  initial begin
    t_reset();
    t_entry();
    t_exit();
    t_pg();
    t_direct_s5();
    t_batt();
    t_hold();
    t_lan();
    t_width();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule